// File: doc/BRIEF.md
# Modem Status Change Scanner

This block watches four modem-status inputs on each of a set of serial lines: ring, carrier, clear-to-send and secondary receive. While scanning is enabled it visits one line per clock, in ascending order, and compares that line's inputs with a stored copy. The first line found with a difference stops the scan. The block reports the line number and the signals that changed, and it can raise an interrupt request. Software services the event and then restarts the scan by writing to the control register.

The same control register has a line-select field. With the scan stopped, software uses this field to pick a line. It can then read that line's live status through the second register address, or drive that line's four control outputs: line enable, DTR, RTS and secondary transmit. Three command bits give extra control. One reloads the scan state, one clears every control output, and one, in maintenance mode, advances the scanner by a single line.

Top module: `modem_scanner`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x0000, every line control output is 0, irq is 0, the stored copy of every line is all zeros, and the scan pointer is at line 0.
- R2: While scan enable (control bit 5) is 1 and the control register is not being written, the scanner compares one line per clock in ascending order and wraps from the last line back to line 0. Busy (control bit 4) reads the same as scan enable.
- R3: When the line under comparison differs from its stored copy, several things happen. The stored copy takes the current inputs. Done (bit 7) is set. Bits 3:0 take the line number. Bits 15, 14, 13 and 12 are set for a change in ring, carrier, clear-to-send and secondary receive respectively. Scan enable is cleared, and scanning stays stopped.
- R4: A write to the control register (address 0) loads line select (bits 3:0), scan enable (bit 5), interrupt enable (bit 6) and maintenance mode (bit 9), and clears done and the four change flags. Writing interrupt enable together with scan enable resumes the scan at the line after the last one compared.
- R5: A read at address 1 returns the selected line's data in bits 7:0, with bits 15:8 zero. The layout is: bit 0 line enable, bit 1 DTR, bit 2 RTS, bit 3 secondary transmit (the control outputs), then bit 4 secondary receive, bit 5 clear-to-send, bit 6 carrier, bit 7 ring (the live inputs).
- R6: A write at address 1 while scan enable is 0 sets the selected line's four control outputs from bits 3:0 of the write data. While scan enable is 1, such a write is ignored.
- R7: Writing control bit 11 as 1 loads every stored copy from the current inputs and sets the scan pointer to line 0. Differences present at that moment are therefore never reported.
- R8: Writing control bit 10 as 1 sets every line's control outputs to 0.
- R9: A control write with maintenance (bit 9) and step (bit 8) set and scan enable clear performs exactly one comparison, in the following clock, on the line at the scan pointer. Bits 8, 10 and 11 always read back as 0.
- R10: irq is 1 exactly when done and interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 the selected line's status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| ring_i | input | NUM_LINES | Ring indicator, one bit per line |
| car_i | input | NUM_LINES | Carrier detect, one bit per line |
| cts_i | input | NUM_LINES | Clear-to-send, one bit per line |
| srx_i | input | NUM_LINES | Secondary receive, one bit per line |
| line_en_o | output | NUM_LINES | Line enable, one bit per line |
| dtr_o | output | NUM_LINES | Data terminal ready, one bit per line |
| rts_o | output | NUM_LINES | Request to send, one bit per line |
| stx_o | output | NUM_LINES | Secondary transmit, one bit per line |

## Verification
The bench builds the block with the default of 16 lines, so the 4-bit line field is fully used. A run of 40 idle scan cycles carries the pointer across the wrap from line 15 to line 0 more than once. The bench places two changes on distant lines at the same time, which tests the ordering of detections. It also reloads the scan state while a difference is pending and shows that the difference is never reported. Finally, maintenance stepping is repeated until a pending carrier change is reached.

// File: rtl/modem_scan_pkg.sv
// Package: shared types and control-register bit positions for the modem
// status scanner. Assumes a 16-bit register word.
package modem_scan_pkg;
    // Four status signals of one line, ordered {ring, carrier, cts, srx}
    typedef logic [3:0] msig_t;

    localparam int CB_SCAN_EN  = 5;
    localparam int CB_INT_EN   = 6;
    localparam int CB_STEP     = 8;
    localparam int CB_MAINT    = 9;
    localparam int CB_CLR_MUX  = 10;
    localparam int CB_CLR_SCAN = 11;
endpackage

// File: rtl/mscan_engine.sv
// Module: mscan_engine
// Holds a stored copy of every line's status inputs and a scan pointer.
// When step_en is high, it compares the line at the pointer and advances
// the pointer, wrapping at the last line. A mismatch raises hit and
// refreshes that line's copy. Assumes clr_scan and step_en never overlap.
module mscan_engine
    import modem_scan_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int SEL_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic                 clr_scan,
    input  logic [NUM_LINES-1:0] ring_i,
    input  logic [NUM_LINES-1:0] car_i,
    input  logic [NUM_LINES-1:0] cts_i,
    input  logic [NUM_LINES-1:0] srx_i,
    output logic                 hit,
    output logic [SEL_W-1:0]     ptr,
    output msig_t                diff
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_LINES - 1);

    msig_t cur    [NUM_LINES];
    msig_t stored [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Gather the live inputs of one line
        assign cur[g] = {ring_i[g], car_i[g], cts_i[g], srx_i[g]};

        // Stored copy: reload on clear, refresh on a detected change
        always_ff @(posedge clk) begin
            if (!rst_n)
                stored[g] <= '0;
            else if (clr_scan)
                stored[g] <= cur[g];
            else if (hit && ptr == SEL_W'(g))
                stored[g] <= cur[g];
        end
    end

    // Difference of the line under the pointer
    assign diff = cur[ptr] ^ stored[ptr];
    assign hit  = step_en && (diff != '0);

    // Scan pointer: advance one line per step, wrap to line 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (clr_scan)
            ptr <= '0;
        else if (step_en)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/mscan_lines.sv
// Module: mscan_lines
// Holds the four control outputs of every line. One line is written
// through the shared select. clr_all zeroes every line. Assumes wr_en and
// clr_all are never both high.
module mscan_lines
    import modem_scan_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int SEL_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 clr_all,
    input  logic [SEL_W-1:0]     sel,
    input  logic [3:0]           wdata,
    output logic [3:0]           sel_ctl,
    output logic [NUM_LINES-1:0] line_en_o,
    output logic [NUM_LINES-1:0] dtr_o,
    output logic [NUM_LINES-1:0] rts_o,
    output logic [NUM_LINES-1:0] stx_o
);
    // ctl bits: {secondary tx, rts, dtr, line enable}
    logic [3:0] ctl [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Per-line control register
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)
                ctl[g] <= '0;
            else if (wr_en && sel == SEL_W'(g))
                ctl[g] <= wdata;
        end
        assign line_en_o[g] = ctl[g][0];
        assign dtr_o[g]     = ctl[g][1];
        assign rts_o[g]     = ctl[g][2];
        assign stx_o[g]     = ctl[g][3];
    end

    // Readback of the selected line
    assign sel_ctl = ctl[sel];
endmodule

// File: rtl/modem_scanner.sv
// Module: modem_scanner (top)
// Control register and scan sequencing for the modem status scanner.
// Address 0 is control/status; address 1 is the selected line's status and
// control outputs. Assumes NUM_LINES <= 16 so the line number fits bits 3:0.
module modem_scanner
    import modem_scan_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    output logic                 irq,
    input  logic [NUM_LINES-1:0] ring_i,
    input  logic [NUM_LINES-1:0] car_i,
    input  logic [NUM_LINES-1:0] cts_i,
    input  logic [NUM_LINES-1:0] srx_i,
    output logic [NUM_LINES-1:0] line_en_o,
    output logic [NUM_LINES-1:0] dtr_o,
    output logic [NUM_LINES-1:0] rts_o,
    output logic [NUM_LINES-1:0] stx_o
);
    localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic             se_q, ie_q, mt_q, done_q, step_q;
    msig_t            flags_q;
    logic [SEL_W-1:0] sel_q;
    logic             wr_ctrl, wr_line, step_en, hit;
    logic [SEL_W-1:0] ptr;
    msig_t            diff;
    logic [3:0]       sel_ctl;

    assign wr_ctrl = reg_wr && !reg_addr;
    assign wr_line = reg_wr && reg_addr && !se_q;
    assign step_en = (se_q || step_q) && !wr_ctrl;

    mscan_engine #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .clr_scan (wr_ctrl && reg_wdata[CB_CLR_SCAN]),
        .ring_i   (ring_i),
        .car_i    (car_i),
        .cts_i    (cts_i),
        .srx_i    (srx_i),
        .hit      (hit),
        .ptr      (ptr),
        .diff     (diff)
    );

    mscan_lines #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_line),
        .clr_all   (wr_ctrl && reg_wdata[CB_CLR_MUX]),
        .sel       (sel_q),
        .wdata     (reg_wdata[3:0]),
        .sel_ctl   (sel_ctl),
        .line_en_o (line_en_o),
        .dtr_o     (dtr_o),
        .rts_o     (rts_o),
        .stx_o     (stx_o)
    );

    // Control register: software writes take priority over detections
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            se_q    <= 1'b0;
            ie_q    <= 1'b0;
            mt_q    <= 1'b0;
            done_q  <= 1'b0;
            flags_q <= '0;
            sel_q   <= '0;
        end else if (wr_ctrl) begin
            se_q    <= reg_wdata[CB_SCAN_EN];
            ie_q    <= reg_wdata[CB_INT_EN];
            mt_q    <= reg_wdata[CB_MAINT];
            done_q  <= 1'b0;
            flags_q <= '0;
            sel_q   <= reg_wdata[SEL_W-1:0];
        end else if (hit) begin
            se_q    <= 1'b0;
            done_q  <= 1'b1;
            flags_q <= diff;
            sel_q   <= ptr;
        end
    end

    // Single-step request from maintenance mode, served the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= 1'b0;
        else
            step_q <= wr_ctrl && reg_wdata[CB_MAINT] && reg_wdata[CB_STEP]
                      && !reg_wdata[CB_SCAN_EN];
    end

    // Read multiplexer for the two register addresses
    always_comb begin
        if (!reg_addr)
            reg_rdata = {flags_q, 2'b00, mt_q, 1'b0, done_q, ie_q, se_q, se_q,
                         4'(sel_q)};
        else
            reg_rdata = {8'h00, ring_i[sel_q], car_i[sel_q], cts_i[sel_q],
                         srx_i[sel_q], sel_ctl};
    end

    assign irq = done_q && ie_q;
endmodule

// File: rtl/mscan_checker.sv
// Module: mscan_checker
// Temporal properties of the scanner, attached to every modem_scanner
// instance by the bind below. Assumes it sees the top's internal state.
module mscan_checker #(
    parameter int NUM_LINES = 16,
    parameter int SEL_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic                 reg_addr,
    input logic [15:0]          reg_wdata,
    input logic                 irq,
    input logic                 se_q,
    input logic                 done_q,
    input logic                 hit,
    input logic [SEL_W-1:0]     ptr,
    input logic [NUM_LINES-1:0] line_en_o,
    input logic [NUM_LINES-1:0] dtr_o,
    input logic [NUM_LINES-1:0] rts_o,
    input logic [NUM_LINES-1:0] stx_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !se_q && !done_q));

    assert_pointer_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (se_q && !(reg_wr && !reg_addr)) |=>
        (ptr == (($past(ptr) == SEL_W'(NUM_LINES - 1)) ? '0 : $past(ptr) + 1'b1)));

    assert_hit_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (done_q && !se_q));

    assert_line_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && se_q) |=>
        $stable({line_en_o, dtr_o, rts_o, stx_o}));

    assert_mux_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata[10]) |=>
        ({line_en_o, dtr_o, rts_o, stx_o} == '0));

    assert_irq_only_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_q && !se_q));
endmodule

bind modem_scanner mscan_checker #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .se_q      (se_q),
    .done_q    (done_q),
    .hit       (hit),
    .ptr       (ptr),
    .line_en_o (line_en_o),
    .dtr_o     (dtr_o),
    .rts_o     (rts_o),
    .stx_o     (stx_o)
);

// File: tb/sim_modem_scanner.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus directed
// checks at the points the requirements call out.
module sim_modem_scanner;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_addr = 1'b0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         irq;
    logic [N-1:0] ring_i = '0, car_i = '0, cts_i = '0, srx_i = '0;
    logic [N-1:0] line_en_o, dtr_o, rts_o, stx_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R1";

    modem_scanner #(.NUM_LINES(N)) u0 (.*);

    always #2 clk = ~clk;

    // Reference model state
    int         m_ptr, m_sel;
    bit         m_se, m_ie, m_mt, m_done, m_step;
    logic [3:0] m_flags;
    logic [3:0] m_st  [N];
    logic [3:0] m_out [N];

    function automatic logic [3:0] live(int l);
        return {ring_i[l], car_i[l], cts_i[l], srx_i[l]};
    endfunction

    function automatic logic [15:0] m_read(bit a);
        if (!a)
            return {m_flags, 2'b00, m_mt, 1'b0, m_done, m_ie, m_se, m_se, 4'(m_sel)};
        return {8'h00, live(m_sel), m_out[m_sel]};
    endfunction

    // Model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_sel = 0; m_se = 0; m_ie = 0; m_mt = 0;
            m_done = 0; m_step = 0; m_flags = 0;
            for (int i = 0; i < N; i++) begin m_st[i] = 0; m_out[i] = 0; end
        end else begin
            bit wc, nstep;
            logic [3:0] d;
            wc = reg_wr && !reg_addr;
            nstep = wc && reg_wdata[9] && reg_wdata[8] && !reg_wdata[5];
            if (reg_wr && reg_addr && !m_se) m_out[m_sel] = reg_wdata[3:0];
            if (wc) begin
                m_se = reg_wdata[5]; m_ie = reg_wdata[6]; m_mt = reg_wdata[9];
                m_sel = int'(reg_wdata[3:0]); m_done = 0; m_flags = 0;
                if (reg_wdata[11]) begin
                    m_ptr = 0;
                    for (int i = 0; i < N; i++) m_st[i] = live(i);
                end
                if (reg_wdata[10])
                    for (int i = 0; i < N; i++) m_out[i] = 0;
            end else if (m_se || m_step) begin
                d = live(m_ptr) ^ m_st[m_ptr];
                if (d != 0) begin
                    m_st[m_ptr] = live(m_ptr);
                    m_done = 1; m_flags = d; m_sel = m_ptr; m_se = 0;
                end
                m_ptr = (m_ptr + 1) % N;
            end
            m_step = nstep;
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 2) begin
            check({tag, " rdata"}, 64'(reg_rdata), 64'(m_read(reg_addr)));
            check("R10 irq", 64'(irq), 64'(m_done && m_ie));
            begin
                logic [N-1:0] e0, e1, e2, e3;
                for (int i = 0; i < N; i++) begin
                    e0[i] = m_out[i][0]; e1[i] = m_out[i][1];
                    e2[i] = m_out[i][2]; e3[i] = m_out[i][3];
                end
                check("R6 outputs", 64'({line_en_o, dtr_o, rts_o, stx_o}),
                      64'({e0, e1, e2, e3}));
            end
        end
        if (cycles > 100000) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic wr(bit a, logic [15:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look(bit a);
        reg_addr = a;
        @(negedge clk);
    endtask

    initial begin
        idle(4);
        look(0);
        check("R1 ctrl after reset", 64'(reg_rdata), 64'h0);
        check("R1 outputs after reset", 64'({line_en_o, dtr_o, rts_o, stx_o}), 64'h0);
        rst_n = 1;

        // R2: idle scan across the wrap, busy mirrors scan enable
        tag = "R2";
        wr(0, 16'h0060);
        idle(40);
        look(0);
        check("R2 scanning busy", 64'(reg_rdata), 64'h0070);

        // R3: ring and carrier change on line 5
        tag = "R3";
        #1; ring_i[5] = 1; car_i[5] = 1;
        idle(20);
        look(0);
        check("R3 detect line 5", 64'(reg_rdata), 64'hC0C5);
        check("R10 irq raised", 64'(irq), 64'h1);

        // R5/R6: select line 3, drive its outputs, read back
        tag = "R5";
        wr(0, 16'h0003);
        wr(1, 16'h000F);
        look(1);
        check("R5 line 3 status", 64'(reg_rdata), 64'h000F);
        check("R6 line 3 dtr", 64'(dtr_o[3]), 64'h1);

        // R4/R6: resume scanning, line write ignored while scanning
        tag = "R4";
        wr(0, 16'h0063);
        look(0);
        check("R4 resume clears done", 64'(reg_rdata), 64'h0073);
        wr(1, 16'h0000);
        look(1);
        check("R6 write ignored while scanning", 64'(reg_rdata), 64'h000F);

        // R3/R4: two changes at once, reported one after the other
        tag = "R3";
        #1; cts_i[0] = 1; srx_i[15] = 1;
        idle(40);
        look(0);
        check("R3 first of two stopped", 64'(reg_rdata[7]), 64'h1);
        wr(0, 16'h0060);
        idle(40);
        look(0);
        check("R4 second of two stopped", 64'(reg_rdata[7]), 64'h1);

        // R7: reload masks a pending change
        tag = "R7";
        wr(0, 16'h0000);
        #1; ring_i[2] = 1;
        wr(0, 16'h0800);
        wr(0, 16'h0060);
        idle(40);
        look(0);
        check("R7 pending change masked", 64'(reg_rdata), 64'h0070);

        // R8: clear all line outputs
        tag = "R8";
        wr(0, 16'h0400);
        look(0);
        check("R8 outputs cleared", 64'({line_en_o, dtr_o, rts_o, stx_o}), 64'h0);

        // R9: single-step in maintenance mode until carrier on line 9 is found
        tag = "R9";
        #1; car_i[9] = 1;
        for (int i = 0; i < 20; i++) begin
            wr(0, 16'h0300);
            @(posedge clk); #1;
            look(0);
            if (reg_rdata[7]) break;
        end
        check("R9 step found line 9", 64'(reg_rdata), 64'h4289);
        check("R10 no irq without enable", 64'(irq), 64'h0);

        idle(4);
        report();
    end
endmodule